// File: doc/BRIEF.md
# Waypoint-Referenced Cycle Counter

This block keeps the cycle counts that a trace unit places in its packets. After software clears the programming bit, a saturating cycle timer starts. Each waypoint instruction samples the timer. A report request asks for a count and an address. The count it returns runs from the previous reference point to the most recent waypoint, not to the cycle of the request. Only a report that actually carries a count moves the reference point. So if tracing was off for a while, the first count after it resumes still covers the whole gap up to the last waypoint.

The block also tracks which target address a synchronization should name. For a periodic sync this is the most recent waypoint target. If there has been no waypoint since the last nonperiodic sync, it is the address that sync used. A nonperiodic sync names the most recent target, whether it came from a waypoint or an exception. Overflow and debug-exit syncs carry a count that must not be trusted, so the block flags it. Building the packets is left to the caller.

Top module: `wp_cycle_ref`

## Requirements
- R1: During and right after a synchronous reset, `rep_valid`, `rep_delta`, `rep_addr` and `rep_unknown` are all zero.
- R2: A report request accepted while `en` is high produces exactly one `rep_valid` pulse on the next cycle. No request means no pulse.
- R3: The timer reads 0 in the cycle after `prog_clr`. The first counted report after that returns the timer value sampled at the latest waypoint, which is the number of cycles from the clear to that waypoint.
- R4: A counted report returns the latest waypoint time minus the reference point, then moves the reference point to that waypoint time. The cycle in which the report is requested has no effect on the value.
- R5: With the reference point at cycle 15, a waypoint at 35 while no report is made, and a trace-on report at 40, the count is 20. A following waypoint at 55, reported at 65, also gives 20.
- R6: Kind 0 (periodic) returns a delta of 0 with `rep_unknown` low, and leaves the reference point unchanged.
- R7: Kinds 2 (overflow) and 3 (debug exit) raise `rep_unknown`, and still move the reference point to the latest waypoint time. Kinds 1 (trace-on) and 4 (plain count) keep `rep_unknown` low.
- R8: A periodic report names the latest waypoint target if a waypoint has occurred since the last nonperiodic report (kinds 1 to 3). Otherwise it names that report's address.
- R9: A nonperiodic report names the latest target from either a waypoint (`wp_exc`=0) or an exception (`wp_exc`=1). An exception target does not sample the timer. A kind 4 report names the latest waypoint target.
- R10: A waypoint and a report in the same cycle are resolved with the waypoint latched first, so its time and address are included in that report.
- R11: While `en` is low, the timer holds its value and waypoint strobes and report requests are ignored.
- R12: The timer saturates at its all-ones value instead of wrapping.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| en | input | 1 | Tracing enabled; gates the timer, strobes and requests |
| prog_clr | input | 1 | Pulse when the programming bit clears; restarts the timer and the reference point |
| wp_valid | input | 1 | Target strobe |
| wp_exc | input | 1 | 1: the strobe is an exception target, 0: a waypoint |
| wp_addr | input | ADDR_W | Target address of the strobe |
| rep_req | input | 1 | Report request |
| rep_kind | input | 3 | 0 periodic, 1 trace-on, 2 overflow, 3 debug exit, 4 plain count |
| rep_valid | output | 1 | Report result valid |
| rep_delta | output | CNT_W | Reported cycle count |
| rep_addr | output | ADDR_W | Address the report names |
| rep_unknown | output | 1 | The count value is unreliable |

## Verification
The bench replays a trace-off gap. A design that measured to the request cycle, or that moved the reference point on every waypoint, would report the wrong value after tracing resumes. Periodic reports are placed between counted ones, so a design that let a periodic report move the reference point shows up in the next count. An exception target followed by periodic reports with no waypoint in between exposes a design that falls back to the wrong address. A same-cycle waypoint and report, a disabled window with live strobes, and a narrow-timer instance check the case that drops the simultaneous waypoint, a timer that keeps running while disabled, and a timer that wraps.

// File: rtl/wp_cc_pkg.sv
package wp_cc_pkg;

    typedef enum logic [2:0] {
        RK_PERIODIC   = 3'd0,
        RK_TRACE_ON   = 3'd1,
        RK_OVERFLOW   = 3'd2,
        RK_DEBUG_EXIT = 3'd3,
        RK_COUNT      = 3'd4
    } rep_kind_e;

    // A report kind other than periodic emits a count and advances the reference.
    function automatic logic kind_counts(rep_kind_e k);
        return k != RK_PERIODIC;
    endfunction

    // Sync reasons other than periodic.
    function automatic logic kind_nonperiodic(rep_kind_e k);
        return (k == RK_TRACE_ON) || (k == RK_OVERFLOW) || (k == RK_DEBUG_EXIT);
    endfunction

    function automatic logic kind_unreliable(rep_kind_e k);
        return (k == RK_OVERFLOW) || (k == RK_DEBUG_EXIT);
    endfunction

endpackage

// File: rtl/wp_cc_timer.sv
module wp_cc_timer #(
    parameter int CNT_W = 32
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             en,
    input  logic             clr,
    output logic [CNT_W-1:0] now
);
    localparam logic [CNT_W-1:0] TOP = '1;

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            now <= '0;
        end else if (en && (now != TOP)) begin
            now <= now + 1'b1;
        end
    end
endmodule

// File: rtl/wp_cc_track.sv
module wp_cc_track #(
    parameter int CNT_W  = 32,
    parameter int ADDR_W = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              clr,
    input  logic              en,
    input  logic [CNT_W-1:0]  now,
    input  logic              wp_valid,
    input  logic              wp_exc,
    input  logic [ADDR_W-1:0] wp_addr,
    input  logic              nonper_take,
    output logic [CNT_W-1:0]  eff_wp_time,
    output logic [ADDR_W-1:0] eff_wp_addr,
    output logic [ADDR_W-1:0] eff_tgt_addr,
    output logic [ADDR_W-1:0] eff_per_addr
);
    logic [CNT_W-1:0]  wp_time_q;
    logic [ADDR_W-1:0] wp_addr_q, tgt_addr_q, nonper_addr_q;
    logic              since_q;
    logic              new_wp, new_exc, eff_since;

    // A strobe in this cycle is folded in before any report reads the state.
    always_comb begin
        new_wp       = en && wp_valid && !wp_exc;
        new_exc      = en && wp_valid && wp_exc;
        eff_wp_time  = new_wp ? now : wp_time_q;
        eff_wp_addr  = new_wp ? wp_addr : wp_addr_q;
        eff_tgt_addr = (new_wp || new_exc) ? wp_addr : tgt_addr_q;
        eff_since    = new_wp || since_q;
        eff_per_addr = eff_since ? eff_wp_addr : nonper_addr_q;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            wp_time_q     <= '0;
            wp_addr_q     <= '0;
            tgt_addr_q    <= '0;
            nonper_addr_q <= '0;
            since_q       <= 1'b0;
        end else begin
            wp_time_q  <= clr ? '0 : eff_wp_time;
            wp_addr_q  <= eff_wp_addr;
            tgt_addr_q <= eff_tgt_addr;
            if (nonper_take) begin
                nonper_addr_q <= eff_tgt_addr;
                since_q       <= 1'b0;
            end else begin
                since_q <= eff_since;
            end
        end
    end
endmodule

// File: rtl/wp_cycle_ref.sv
module wp_cycle_ref
    import wp_cc_pkg::*;
#(
    parameter int CNT_W  = 32,
    parameter int ADDR_W = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              en,
    input  logic              prog_clr,
    input  logic              wp_valid,
    input  logic              wp_exc,
    input  logic [ADDR_W-1:0] wp_addr,
    input  logic              rep_req,
    input  logic [2:0]        rep_kind,
    output logic              rep_valid,
    output logic [CNT_W-1:0]  rep_delta,
    output logic [ADDR_W-1:0] rep_addr,
    output logic              rep_unknown
);
    logic [CNT_W-1:0]  now_w, eff_wp_time, ref_q, delta_n;
    logic [ADDR_W-1:0] eff_wp_addr, eff_tgt_addr, eff_per_addr, addr_n;
    rep_kind_e         kind;
    logic              take, nonper_take, counted;

    always_comb begin
        kind        = rep_kind_e'(rep_kind);
        take        = en && rep_req;
        nonper_take = take && kind_nonperiodic(kind);
        counted     = kind_counts(kind);
        delta_n     = counted ? (eff_wp_time - ref_q) : '0;
        if (kind_nonperiodic(kind))     addr_n = eff_tgt_addr;
        else if (kind == RK_PERIODIC)   addr_n = eff_per_addr;
        else                            addr_n = eff_wp_addr;
    end

    wp_cc_timer #(.CNT_W(CNT_W)) u_timer (
        .clk (clk),
        .rst (rst),
        .en  (en),
        .clr (prog_clr),
        .now (now_w)
    );

    wp_cc_track #(.CNT_W(CNT_W), .ADDR_W(ADDR_W)) u_track (
        .clk          (clk),
        .rst          (rst),
        .clr          (prog_clr),
        .en           (en),
        .now          (now_w),
        .wp_valid     (wp_valid),
        .wp_exc       (wp_exc),
        .wp_addr      (wp_addr),
        .nonper_take  (nonper_take),
        .eff_wp_time  (eff_wp_time),
        .eff_wp_addr  (eff_wp_addr),
        .eff_tgt_addr (eff_tgt_addr),
        .eff_per_addr (eff_per_addr)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            ref_q       <= '0;
            rep_valid   <= 1'b0;
            rep_delta   <= '0;
            rep_addr    <= '0;
            rep_unknown <= 1'b0;
        end else begin
            rep_valid <= take;
            if (prog_clr)               ref_q <= '0;
            else if (take && counted)   ref_q <= eff_wp_time;
            if (take) begin
                rep_delta   <= delta_n;
                rep_addr    <= addr_n;
                rep_unknown <= kind_unreliable(kind);
            end
        end
    end
endmodule

// File: rtl/wp_cycle_ref_chk.sv
module wp_cycle_ref_chk #(
    parameter int CNT_W = 32
) (
    input logic             clk,
    input logic             rst,
    input logic             en,
    input logic             prog_clr,
    input logic             rep_req,
    input logic [2:0]       rep_kind,
    input logic             rep_valid,
    input logic [CNT_W-1:0] rep_delta,
    input logic             rep_unknown,
    input logic [CNT_W-1:0] now_w
);
    assert_reset_quiet_R1: assert property (@(posedge clk)
        rst |=> (!rep_valid && !rep_unknown && rep_delta == '0));

    assert_pulse_on_req_R2: assert property (@(posedge clk) disable iff (rst)
        (en && rep_req) |=> rep_valid);

    assert_no_pulse_idle_R2: assert property (@(posedge clk) disable iff (rst)
        !(en && rep_req) |=> !rep_valid);

    assert_periodic_no_count_R6: assert property (@(posedge clk) disable iff (rst)
        (rep_valid && $past(rep_kind) == 3'd0) |-> (rep_delta == '0 && !rep_unknown));

    assert_unknown_flag_R7: assert property (@(posedge clk) disable iff (rst)
        rep_valid |-> (rep_unknown == ($past(rep_kind) == 3'd2 || $past(rep_kind) == 3'd3)));

    assert_idle_hold_R11: assert property (@(posedge clk) disable iff (rst)
        (!en && !prog_clr) |=> $stable(now_w));

    assert_saturate_R12: assert property (@(posedge clk) disable iff (rst)
        (now_w == '1 && !prog_clr) |=> (now_w == '1));
endmodule

bind wp_cycle_ref wp_cycle_ref_chk #(.CNT_W(CNT_W)) u_chk (
    .clk         (clk),
    .rst         (rst),
    .en          (en),
    .prog_clr    (prog_clr),
    .rep_req     (rep_req),
    .rep_kind    (rep_kind),
    .rep_valid   (rep_valid),
    .rep_delta   (rep_delta),
    .rep_unknown (rep_unknown),
    .now_w       (now_w)
);

// File: tb/sim_wp_cycle_ref.sv
module sim_wp_cycle_ref;

    typedef struct packed {
        logic [7:0]  idle;
        logic        wp;
        logic        exc;
        logic [31:0] addr;
        logic        req;
        logic [2:0]  kind;
        logic        chk_delta;
        logic [31:0] e_delta;
        logic [31:0] e_addr;
        logic        e_unk;
        logic [7:0]  tag;
    } vec_t;

    // Cycle index t counts from 0 in the cycle after prog_clr.
    localparam vec_t VEC [17] = '{
        '{8'd5,  1'b1, 1'b0, 32'h100, 1'b0, 3'd0, 1'b0, 32'd0,  32'h0,   1'b0, 8'd3},  // t5 wp
        '{8'd2,  1'b0, 1'b0, 32'h0,   1'b1, 3'd4, 1'b1, 32'd5,  32'h100, 1'b0, 8'd3},  // t8 R3
        '{8'd6,  1'b1, 1'b0, 32'h200, 1'b0, 3'd0, 1'b0, 32'd0,  32'h0,   1'b0, 8'd4},  // t15 wp
        '{8'd0,  1'b0, 1'b0, 32'h0,   1'b1, 3'd4, 1'b1, 32'd10, 32'h200, 1'b0, 8'd4},  // t16 R4
        '{8'd18, 1'b1, 1'b0, 32'h300, 1'b0, 3'd0, 1'b0, 32'd0,  32'h0,   1'b0, 8'd5},  // t35 wp, no report
        '{8'd4,  1'b0, 1'b0, 32'h0,   1'b1, 3'd1, 1'b1, 32'd20, 32'h300, 1'b0, 8'd5},  // t40 R5 trace-on
        '{8'd14, 1'b1, 1'b0, 32'h400, 1'b0, 3'd0, 1'b0, 32'd0,  32'h0,   1'b0, 8'd5},  // t55 wp
        '{8'd9,  1'b0, 1'b0, 32'h0,   1'b1, 3'd4, 1'b1, 32'd20, 32'h400, 1'b0, 8'd5},  // t65 R5
        '{8'd0,  1'b0, 1'b0, 32'h0,   1'b1, 3'd0, 1'b1, 32'd0,  32'h400, 1'b0, 8'd8},  // t66 R8/R6 periodic
        '{8'd0,  1'b1, 1'b1, 32'h500, 1'b0, 3'd0, 1'b0, 32'd0,  32'h0,   1'b0, 8'd9},  // t67 exception
        '{8'd0,  1'b0, 1'b0, 32'h0,   1'b1, 3'd2, 1'b0, 32'd0,  32'h500, 1'b1, 8'd9},  // t68 R9/R7 overflow
        '{8'd0,  1'b0, 1'b0, 32'h0,   1'b1, 3'd0, 1'b1, 32'd0,  32'h500, 1'b0, 8'd8},  // t69 R8 fallback
        '{8'd0,  1'b1, 1'b0, 32'h600, 1'b1, 3'd4, 1'b1, 32'd15, 32'h600, 1'b0, 8'd10}, // t70 R10 same cycle
        '{8'd0,  1'b0, 1'b0, 32'h0,   1'b1, 3'd0, 1'b1, 32'd0,  32'h600, 1'b0, 8'd6},  // t71 R6 periodic
        '{8'd0,  1'b0, 1'b0, 32'h0,   1'b1, 3'd3, 1'b0, 32'd0,  32'h600, 1'b1, 8'd7},  // t72 R7 debug exit
        '{8'd9,  1'b1, 1'b0, 32'h700, 1'b0, 3'd0, 1'b0, 32'd0,  32'h0,   1'b0, 8'd7},  // t82 wp
        '{8'd0,  1'b0, 1'b0, 32'h0,   1'b1, 3'd4, 1'b1, 32'd12, 32'h700, 1'b0, 8'd7}   // t83 R7 ref moved
    };

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        en = 1'b0, prog_clr = 1'b0, wp_valid = 1'b0, wp_exc = 1'b0, rep_req = 1'b0;
    logic [31:0] wp_addr = '0;
    logic [2:0]  rep_kind = '0;
    logic        rep_valid, rep_unknown, s_valid, s_unknown;
    logic [31:0] rep_delta, rep_addr, s_addr;
    logic [3:0]  s_delta;
    int          errors = 0, checks = 0, cycles = 0;
    bit          done = 1'b0;

    always #4 clk = ~clk;

    wp_cycle_ref u0 (
        .clk(clk), .rst(rst), .en(en), .prog_clr(prog_clr),
        .wp_valid(wp_valid), .wp_exc(wp_exc), .wp_addr(wp_addr),
        .rep_req(rep_req), .rep_kind(rep_kind),
        .rep_valid(rep_valid), .rep_delta(rep_delta), .rep_addr(rep_addr),
        .rep_unknown(rep_unknown)
    );

    wp_cycle_ref #(.CNT_W(4)) u1 (
        .clk(clk), .rst(rst), .en(en), .prog_clr(prog_clr),
        .wp_valid(wp_valid), .wp_exc(wp_exc), .wp_addr(wp_addr),
        .rep_req(rep_req), .rep_kind(rep_kind),
        .rep_valid(s_valid), .rep_delta(s_delta), .rep_addr(s_addr),
        .rep_unknown(s_unknown)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic quiet();
        wp_valid = 1'b0; wp_exc = 1'b0; rep_req = 1'b0; prog_clr = 1'b0;
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > 5000 && !done) begin
            errors++; checks++;
            $display("FAIL watchdog: actual=%0d expected<=5000 cycles", cycles);
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1: outputs zero during reset
        check("R1 valid", {31'd0, rep_valid}, 32'd0);
        rst = 1'b0;
        @(negedge clk);
        check("R1 delta", rep_delta, 32'd0);
        check("R1 addr", rep_addr, 32'd0);
        check("R1 unknown", {31'd0, rep_unknown}, 32'd0);

        en = 1'b1; prog_clr = 1'b1;
        @(negedge clk);
        quiet();

        for (int i = 0; i < 17; i++) begin
            for (int k = 0; k < int'(VEC[i].idle); k++) @(negedge clk);
            wp_valid = VEC[i].wp; wp_exc = VEC[i].exc; wp_addr = VEC[i].addr;
            rep_req = VEC[i].req; rep_kind = VEC[i].kind;
            @(negedge clk);
            if (VEC[i].req) begin
                check($sformatf("R2 valid vec%0d", i), {31'd0, rep_valid}, 32'd1);
                check($sformatf("R%0d addr vec%0d", VEC[i].tag, i), rep_addr, VEC[i].e_addr);
                check($sformatf("R7 unknown vec%0d", i), {31'd0, rep_unknown}, {31'd0, VEC[i].e_unk});
                if (VEC[i].chk_delta)
                    check($sformatf("R%0d delta vec%0d", VEC[i].tag, i), rep_delta, VEC[i].e_delta);
            end
            quiet();
        end

        // R2: single pulse, nothing without a request (t84)
        @(negedge clk);
        check("R2 no pulse", {31'd0, rep_valid}, 32'd0);

        // R11: disabled window with live strobes and requests; timer holds at 85
        en = 1'b0; wp_valid = 1'b1; wp_addr = 32'h900; rep_req = 1'b1; rep_kind = 3'd4;
        for (int k = 0; k < 10; k++) begin
            @(negedge clk);
            check("R11 ignored req", {31'd0, rep_valid}, 32'd0);
        end
        quiet(); en = 1'b1; rep_req = 1'b1; rep_kind = 3'd0;
        @(negedge clk);
        check("R11 periodic addr", rep_addr, 32'h700);
        quiet(); wp_valid = 1'b1; wp_addr = 32'h800; rep_req = 1'b1; rep_kind = 3'd4;
        @(negedge clk);
        check("R11 timer held delta", rep_delta, 32'd4);
        check("R10 addr", rep_addr, 32'h800);
        quiet();

        // R12 and R3: restart, 20 cycles, then waypoint+report
        prog_clr = 1'b1;
        @(negedge clk);
        quiet();
        repeat (20) @(negedge clk);
        wp_valid = 1'b1; wp_addr = 32'hA00; rep_req = 1'b1; rep_kind = 3'd4;
        @(negedge clk);
        check("R3 restart delta", rep_delta, 32'd20);
        check("R12 saturated delta", {28'd0, s_delta}, 32'd15);
        quiet();

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule